// File: doc/BRIEF.md
# Asymmetric Decoder Slot Steering

This block sits between an instruction window and a set of three decoders of unequal strength. Each cycle it sees the three oldest pending macro-instructions, each tagged with a valid bit, a precomputed micro-op count and an opaque payload. The oldest entry always goes to the general decoder. That decoder expands an instruction of any size, up to four micro-ops per cycle, and spends as many cycles as the count demands. The two younger entries are offered in order to two restricted decoders. A restricted decoder can only handle an instruction that becomes exactly one micro-op.

The output is a row of six micro-op slots. Slots 0 to 3 belong to the general decoder and slots 4 and 5 to the restricted decoders, and slot index order is program order. The row carries one valid flag, and a downstream ready qualifies it. A consumed count tells the window how many macro-instructions to retire from its head. The window must keep presenting the same head instruction until that instruction is consumed.

Top module: `uop_steer`

## Requirements
- R1: When window slot 0 is not valid, `out_valid` is 0, every `uop_valid` bit is 0 and `consumed` is 0.
- R2: With slot 0 valid, the general decoder fills slots 0..n-1, where n = min(remaining micro-ops of the head instruction, 4). Each of these slots carries the head's payload.
- R3: A micro-op count of 0 is handled exactly like a count of 1: one micro-op is emitted and the instruction may be followed by restricted decodes.
- R4: An instruction needing more than 4 micro-ops is emitted 4 per accepted cycle until its remainder is 4 or fewer. During the non-final cycles, slots 4 and 5 are empty and `consumed` is 0.
- R5: Restricted slot 4 takes window slot 1, and restricted slot 5 takes window slot 2, only on the head's final cycle. Each take requires the entry to be valid and to need exactly one micro-op (a count of 0 or 1). The first entry that fails stops all later ones, even a simple one.
- R6: An invalid window slot 1 prevents window slot 2 from being taken, even when slot 2 is valid and simple.
- R7: On the head's final cycle with `out_ready` high, `consumed` equals 1 plus the number of restricted slots taken. In every other cycle it is 0.
- R8: While `out_valid` is high and `out_ready` is low, no progress is made: the next cycle with the same window shows the same micro-op row.
- R9: The `uop_idx` of general slot j is the number of the head's micro-ops already accepted plus j, so micro-ops leave in program order. Restricted slots carry index 0.
- R10: After reset, the head's accepted micro-op count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Valid bit per window slot, bit 0 oldest |
| in_cnt | input | 12 | 4-bit micro-op count per window slot, slot k at bits 4k+3:4k |
| in_pay | input | 48 | 16-bit payload per window slot, slot k at bits 16k+15:16k |
| out_ready | input | 1 | Downstream accepts the micro-op row |
| out_valid | output | 1 | Micro-op row is valid |
| uop_valid | output | 6 | Per-slot valid, slots 0-3 general, 4-5 restricted |
| uop_pay | output | 96 | 16-bit payload per micro-op slot |
| uop_idx | output | 24 | 4-bit micro-op index within its instruction per slot |
| consumed | output | 2 | Macro-instructions retired from the window this cycle |

## Verification
The bound checker watches, on every cycle, the relations that hold locally. Nothing leaves when the head is invalid. A nonzero consumed count only appears with a completed handshake. Restricted slots are empty during a long expansion. The second restricted slot never fires without the first. Every taken entry is valid and simple. The sequencer offset holds during a stall and steps by four on a non-final accepted cycle. The bench's reference model alone can show the exact contents of the row: the burst lengths over a multi-cycle expansion, the micro-op indices, the effect of a complex or missing entry on later simple ones, and the count returned to the window.

// File: rtl/uop_steer_pkg.sv
package uop_steer_pkg;

  // Micro-ops an instruction really needs: a zero count still costs one.
  function automatic int uop_need(input int cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  // Micro-ops the general decoder can emit this cycle.
  function automatic int burst_len(input int remaining, input int width);
    return (remaining > width) ? width : remaining;
  endfunction

  // A restricted decoder only takes single micro-op instructions.
  function automatic bit is_simple(input int cnt);
    return uop_need(cnt) == 1;
  endfunction

endpackage

// File: rtl/uop_gen_seq.sv
module uop_gen_seq
  import uop_steer_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int GEN_W = 4,
  localparam int BW   = $clog2(GEN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic [CNT_W-1:0] head_cnt,
  input  logic             accept,
  output logic [BW-1:0]    burst,
  output logic [CNT_W-1:0] done_q,
  output logic             last
);

  logic [CNT_W-1:0] need_w;
  logic [CNT_W-1:0] rem;

  always_comb begin
    need_w = CNT_W'(uop_need(int'(head_cnt)));
    rem    = need_w - done_q;
    last   = int'(rem) <= GEN_W;
    burst  = head_valid ? BW'(burst_len(int'(rem), GEN_W)) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
    end else if (head_valid && accept) begin
      if (last) done_q <= '0;
      else      done_q <= done_q + CNT_W'(GEN_W);
    end
  end

endmodule

// File: rtl/uop_restr_chain.sv
module uop_restr_chain
  import uop_steer_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NUM_RES = 2
) (
  input  logic                     enable,
  input  logic [NUM_RES-1:0]       valid,
  input  logic [NUM_RES*CNT_W-1:0] cnt,
  output logic [NUM_RES-1:0]       take
);

  always_comb begin
    logic go;
    go = enable;
    for (int k = 0; k < NUM_RES; k++) begin
      go      = go && valid[k] && is_simple(int'(cnt[k*CNT_W +: CNT_W]));
      take[k] = go;
    end
  end

endmodule

// File: rtl/uop_slot_pack.sv
module uop_slot_pack #(
  parameter int CNT_W   = 4,
  parameter int PAY_W   = 16,
  parameter int GEN_W   = 4,
  parameter int NUM_RES = 2,
  localparam int BW     = $clog2(GEN_W + 1),
  localparam int SLOTS  = GEN_W + NUM_RES
) (
  input  logic [BW-1:0]            burst,
  input  logic [CNT_W-1:0]         base_idx,
  input  logic [PAY_W-1:0]         head_pay,
  input  logic [NUM_RES-1:0]       take,
  input  logic [NUM_RES*PAY_W-1:0] res_pay,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [SLOTS*PAY_W-1:0]   slot_pay,
  output logic [SLOTS*CNT_W-1:0]   slot_idx
);

  for (genvar j = 0; j < GEN_W; j++) begin : g_gen
    assign slot_valid[j]                 = BW'(j) < burst;
    assign slot_pay[j*PAY_W +: PAY_W]    = head_pay;
    assign slot_idx[j*CNT_W +: CNT_W]    = base_idx + CNT_W'(j);
  end

  for (genvar k = 0; k < NUM_RES; k++) begin : g_res
    localparam int S = GEN_W + k;
    assign slot_valid[S]                 = take[k];
    assign slot_pay[S*PAY_W +: PAY_W]    = res_pay[k*PAY_W +: PAY_W];
    assign slot_idx[S*CNT_W +: CNT_W]    = '0;
  end

endmodule

// File: rtl/uop_steer.sv
module uop_steer #(
  parameter int CNT_W   = 4,
  parameter int PAY_W   = 16,
  parameter int GEN_W   = 4,
  parameter int NUM_RES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_RES:0]                   in_valid,
  input  logic [(NUM_RES+1)*CNT_W-1:0]       in_cnt,
  input  logic [(NUM_RES+1)*PAY_W-1:0]       in_pay,
  input  logic                               out_ready,
  output logic                               out_valid,
  output logic [GEN_W+NUM_RES-1:0]           uop_valid,
  output logic [(GEN_W+NUM_RES)*PAY_W-1:0]   uop_pay,
  output logic [(GEN_W+NUM_RES)*CNT_W-1:0]   uop_idx,
  output logic [$clog2(NUM_RES+2)-1:0]       consumed
);

  localparam int BW     = $clog2(GEN_W + 1);
  localparam int CONS_W = $clog2(NUM_RES + 2);

  // Named internal events, observed by the bound checker.
  logic                   gen_last;
  logic [CNT_W-1:0]       gen_done;
  logic [BW-1:0]          gen_burst;
  logic [NUM_RES-1:0]     res_take;
  logic                   row_accept;

  assign out_valid  = in_valid[0];
  assign row_accept = out_valid && out_ready;

  uop_gen_seq #(.CNT_W(CNT_W), .GEN_W(GEN_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (in_valid[0]),
    .head_cnt   (in_cnt[CNT_W-1:0]),
    .accept     (out_ready),
    .burst      (gen_burst),
    .done_q     (gen_done),
    .last       (gen_last)
  );

  uop_restr_chain #(.CNT_W(CNT_W), .NUM_RES(NUM_RES)) u_res (
    .enable (in_valid[0] && gen_last),
    .valid  (in_valid[NUM_RES:1]),
    .cnt    (in_cnt[(NUM_RES+1)*CNT_W-1:CNT_W]),
    .take   (res_take)
  );

  uop_slot_pack #(.CNT_W(CNT_W), .PAY_W(PAY_W), .GEN_W(GEN_W), .NUM_RES(NUM_RES)) u_pack (
    .burst      (gen_burst),
    .base_idx   (gen_done),
    .head_pay   (in_pay[PAY_W-1:0]),
    .take       (res_take),
    .res_pay    (in_pay[(NUM_RES+1)*PAY_W-1:PAY_W]),
    .slot_valid (uop_valid),
    .slot_pay   (uop_pay),
    .slot_idx   (uop_idx)
  );

  always_comb begin
    if (row_accept && gen_last) consumed = CONS_W'(1 + $countones(res_take));
    else                        consumed = '0;
  end

endmodule

// File: rtl/uop_steer_chk.sv
module uop_steer_chk #(
  parameter int CNT_W   = 4,
  parameter int GEN_W   = 4,
  parameter int NUM_RES = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_RES:0]               in_valid,
  input logic [(NUM_RES+1)*CNT_W-1:0]   in_cnt,
  input logic                           out_ready,
  input logic                           out_valid,
  input logic [GEN_W+NUM_RES-1:0]       uop_valid,
  input logic [$clog2(NUM_RES+2)-1:0]   consumed,
  input logic                           gen_last,
  input logic [CNT_W-1:0]               gen_done
);

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |-> (!out_valid && uop_valid == '0 && consumed == '0));

  a_r2_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> uop_valid[0]);

  a_r7_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (consumed != '0) |-> (out_valid && out_ready));

  a_r4_quiet_restricted: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !gen_last) |-> (uop_valid[GEN_W+NUM_RES-1:GEN_W] == '0 && consumed == '0));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !gen_last) |=> (gen_done == $past(gen_done) + CNT_W'(GEN_W)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(gen_done));

  for (genvar k = 0; k < NUM_RES; k++) begin : g_res
    a_r5_simple: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid[GEN_W+k] |-> (in_valid[k+1] && in_cnt[(k+1)*CNT_W +: CNT_W] <= CNT_W'(1)));
    if (k > 0) begin : g_ord
      a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid[GEN_W+k] |-> uop_valid[GEN_W+k-1]);
    end
  end

endmodule

bind uop_steer uop_steer_chk #(.CNT_W(CNT_W), .GEN_W(GEN_W), .NUM_RES(NUM_RES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_cnt    (in_cnt),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .uop_valid (uop_valid),
  .consumed  (consumed),
  .gen_last  (gen_last),
  .gen_done  (gen_done)
);

// File: tb/sim_uop_steer.sv
module sim_uop_steer;

  localparam int N = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  in_valid = '0;
  logic [11:0] in_cnt = '0;
  logic [47:0] in_pay = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [5:0]  uop_valid;
  logic [95:0] uop_pay;
  logic [23:0] uop_idx;
  logic [1:0]  consumed;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int s_cnt [N];
  int s_pay [N];
  int head = 0;
  int off = 0;

  always #10 clk = ~clk;

  uop_steer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt), .in_pay(in_pay),
    .out_ready(out_ready), .out_valid(out_valid), .uop_valid(uop_valid),
    .uop_pay(uop_pay), .uop_idx(uop_idx), .consumed(consumed)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (head=%0d off=%0d)", tag, act, exp, head, off);
    end
  endtask

  function automatic int cost(input int c);
    if (c < 1) return 1;
    return c;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int cyc;
    int pre [13] = '{0, 1, 1, 9, 1, 2, 1, 3, 3, 1, 4, 0, 15};
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < N; i++) begin
      if (i < 13) s_cnt[i] = pre[i];
      else s_cnt[i] = ($urandom % 10 < 6) ? 1 : int'($urandom % 16);
      s_pay[i] = int'($urandom % 65536);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && uop_valid == '0, "R1 reset idle", int'(uop_valid), 0);
    chk(consumed == 2'd0, "R7 reset consumed", int'(consumed), 0);
    rst_n = 1'b1;

    cyc = 0;
    while (head < N && cyc < 5000) begin
      int v [3];
      int pick;
      bit hole;
      int need0, rem, nb, ntake;
      bit last, stop;
      @(negedge clk);
      hole = 0;
      pick = (cyc < 40) ? 9 : int'($urandom % 10);
      if (cyc == 25) pick = 0;
      v = '{1, 1, 1};
      case (pick)
        0: begin v = '{1, 0, 1}; hole = 1; end
        1: v = '{0, 0, 0};
        2: v = '{1, 0, 0};
        3: v = '{1, 1, 0};
        default: ;
      endcase
      for (int k = 0; k < 3; k++) begin
        if (head + k >= N) v[k] = 0;
        in_valid[k] = v[k][0];
        in_cnt[k*4 +: 4] = (head + k < N) ? 4'(s_cnt[head+k]) : 4'(0);
        in_pay[k*16 +: 16] = (head + k < N) ? 16'(s_pay[head+k]) : 16'(0);
      end
      out_ready = (cyc == 3 || cyc == 4) ? 1'b0 :
                  (cyc < 40) ? 1'b1 : (($urandom % 5) != 0);
      #2;

      if (v[0] == 0) begin
        chk(out_valid == 1'b0 && uop_valid == '0 && consumed == 2'd0, "R1 head invalid",
            int'(uop_valid), 0);
      end else begin
        need0 = cost(s_cnt[head]);
        rem = need0 - off;
        nb = (rem < 4) ? rem : 4;
        last = (rem <= 4);
        chk(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
        for (int j = 0; j < 4; j++) begin
          chk(uop_valid[j] == (j < nb), (s_cnt[head] == 0) ? "R3 zero-count burst" : "R2 burst",
              int'(uop_valid[j]), int'(j < nb));
          if (j < nb) begin
            chk(int'(uop_pay[j*16 +: 16]) == s_pay[head], "R2 payload",
                int'(uop_pay[j*16 +: 16]), s_pay[head]);
            chk(int'(uop_idx[j*4 +: 4]) == off + j, "R9 index", int'(uop_idx[j*4 +: 4]), off + j);
          end
        end
        ntake = 0;
        stop = !last;
        for (int k = 1; k < 3; k++) begin
          bit t;
          t = !stop && v[k] == 1 && cost(s_cnt[head+k]) == 1;
          if (!t) stop = 1;
          if (t) ntake++;
          chk(uop_valid[3+k] == t, hole ? "R6 hole" : (last ? "R5 restricted" : "R4 restricted idle"),
              int'(uop_valid[3+k]), int'(t));
          if (t) chk(int'(uop_pay[(3+k)*16 +: 16]) == s_pay[head+k], "R5 payload",
                     int'(uop_pay[(3+k)*16 +: 16]), s_pay[head+k]);
        end
        if (!out_ready) chk(consumed == 2'd0, "R8 stall", int'(consumed), 0);
        else if (!last) chk(consumed == 2'd0, "R4 mid expansion", int'(consumed), 0);
        else chk(int'(consumed) == 1 + ntake, "R7 consumed", int'(consumed), 1 + ntake);

        @(posedge clk);
        if (out_ready) begin
          if (last) begin head += 1 + ntake; off = 0; end
          else off += 4;
        end
      end
      cyc++;
    end

    // R10: reset during an expansion restarts the head at micro-op 0.
    @(negedge clk);
    s_cnt[0] = 9; s_pay[0] = 16'h0ABC;
    in_valid = 3'b001; in_cnt = 12'd9; in_pay = 48'h0ABC; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(uop_idx[3:0] == 4'd0 && uop_valid[3:0] == 4'hF, "R10 restart index", int'(uop_idx[3:0]), 0);

    finished = 1;
    summary();
  end

endmodule